// File: doc/BRIEF.md
# Pin Change Interrupt Generator

This block raises an interrupt request when a pin that is set up as an input no longer matches the value most recently captured for it in its port's input register. The pins are grouped into ports of equal width. Each port keeps its own pending flag. The single interrupt line goes low while any port has a flag set. The surrounding expander logic supplies four things: the synchronized pin levels, the direction bits, the captured input-register contents and one read strobe per port.

The comparison is level based. The request stays up while a watched pin differs from its captured bit. It drops when the pin returns to the captured level. It also drops when the affected port is read, because the read strobe clears that port's flag and the surrounding logic recaptures the register at the same edge. A read of one port never touches another port's flag. Pins driven as outputs are masked out of the comparison. A pin that is turned from output to input can therefore raise a request at once if its level disagrees with the stored bit. The comparison uses raw pin levels and raw captured values. Any read-data polarity inversion is applied elsewhere.

Top module: `pin_change_irq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no mismatch present, `irq_n` is 1 and no port flag is set, whatever the inputs are.
- R2: Port p occupies bits `[p*PORT_W +: PORT_W]` of `pin_lvl`, `pin_is_in` and `cap_val`. If a bit with `pin_is_in`=1 has `pin_lvl` different from `cap_val` and `port_rd[p]` is 0, `irq_n` is 0 after the next rising clock edge.
- R3: A bit with `pin_is_in`=0 (output) never contributes. Toggling its pin level leaves `irq_n` unchanged.
- R4: When every watched pin of a port returns to its captured value, that port's request is gone after the next rising edge.
- R5: `port_rd[p]`=1 in a cycle clears port p's flag at that edge, even if the mismatch is still present.
- R6: `port_rd[p]` has no effect on any other port's flag. A mismatch on another port keeps `irq_n` at 0.
- R7: Changing a bit of `pin_is_in` from 0 to 1 while its pin differs from its captured bit raises the request one edge later.
- R8: `irq_n` is a register output. It is 0 exactly when at least one port flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PORTS*PORT_W | Synchronized pin levels |
| pin_is_in | input | NUM_PORTS*PORT_W | Direction per pin, 1 = input |
| cap_val | input | NUM_PORTS*PORT_W | Contents of the input registers, last captured values |
| port_rd | input | NUM_PORTS | Read strobe per port, one cycle |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Directed cases cover the single-bit flips that must separate the following:
- a watched pin from a masked pin;
- a revert from a read;
- a read of the port that holds the mismatch from a read of the other port.

They also cover a direction change from output to input over a mismatched pin. Random cycles use sparse difference masks and random direction words, so that mismatches fall both on masked bits and on watched bits. They also mix in occasional reads, which shows whether the read override and the OR across ports are correct under overlap. Every cycle's output is compared with a model that the bench computes from the requirements.

// File: rtl/pci_pkg.sv
package pci_pkg;
  localparam int DEF_PORT_W    = 8;
  localparam int DEF_NUM_PORTS = 2;
endpackage

// File: rtl/pci_port_watch.sv
module pci_port_watch #(
  parameter int PORT_W = pci_pkg::DEF_PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] lvl,
  input  logic [PORT_W-1:0] is_in,
  input  logic [PORT_W-1:0] snap,
  input  logic              rd,
  output logic              diff_any,
  output logic              pend_d,
  output logic              pend_q
);
  function automatic logic [PORT_W-1:0] watched_diff(
    input logic [PORT_W-1:0] l, input logic [PORT_W-1:0] d,
    input logic [PORT_W-1:0] s);
    return (l ^ s) & d;
  endfunction

  logic [PORT_W-1:0] diff_bits;

  always_comb begin
    diff_bits = watched_diff(lvl, is_in, snap);
    diff_any  = |diff_bits;
    pend_d    = diff_any & ~rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/pci_irq_merge.sv
module pci_irq_merge #(
  parameter int NUM_PORTS = pci_pkg::DEF_NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] pend_d,
  output logic                 irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~(|pend_d);
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int PORT_W    = pci_pkg::DEF_PORT_W,
  parameter int NUM_PORTS = pci_pkg::DEF_NUM_PORTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_lvl,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_is_in,
  input  logic [NUM_PORTS*PORT_W-1:0] cap_val,
  input  logic [NUM_PORTS-1:0]        port_rd,
  output logic                        irq_n
);
  logic [NUM_PORTS-1:0] diff_any;
  logic [NUM_PORTS-1:0] pend_d;
  logic [NUM_PORTS-1:0] pend_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pci_port_watch #(.PORT_W(PORT_W)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_lvl[p*PORT_W +: PORT_W]),
      .is_in    (pin_is_in[p*PORT_W +: PORT_W]),
      .snap     (cap_val[p*PORT_W +: PORT_W]),
      .rd       (port_rd[p]),
      .diff_any (diff_any[p]),
      .pend_d   (pend_d[p]),
      .pend_q   (pend_q[p])
    );
  end

  pci_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_d (pend_d),
    .irq_n  (irq_n)
  );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int PORT_W    = pci_pkg::DEF_PORT_W,
  parameter int NUM_PORTS = pci_pkg::DEF_NUM_PORTS
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_PORTS*PORT_W-1:0] pin_lvl,
  input logic [NUM_PORTS*PORT_W-1:0] pin_is_in,
  input logic [NUM_PORTS*PORT_W-1:0] cap_val,
  input logic [NUM_PORTS-1:0]        port_rd,
  input logic                        irq_n,
  input logic [NUM_PORTS-1:0]        pend_q
);
  logic [NUM_PORTS-1:0] mis;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mis
    assign mis[p] = ((pin_lvl[p*PORT_W +: PORT_W] ^ cap_val[p*PORT_W +: PORT_W])
                     & pin_is_in[p*PORT_W +: PORT_W]) != '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (irq_n && pend_q == '0);
    end
  end

  p_any_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == (pend_q == '0));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_prop
    p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mis[p] && !port_rd[p]) |=> pend_q[p]);
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mis[p] |=> !pend_q[p]);
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      port_rd[p] |=> !pend_q[p]);
    if (NUM_PORTS > 1) begin : g_other
      localparam int Q = (p + 1) % NUM_PORTS;
      p_other_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd[p] && mis[Q] && !port_rd[Q]) |=> (pend_q[Q] && !irq_n));
    end
  end
endmodule

bind pin_change_irq pin_change_irq_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_is_in(pin_is_in),
  .cap_val(cap_val), .port_rd(port_rd), .irq_n(irq_n), .pend_q(pend_q));

// File: tb/tb_pin_change_irq.sv
`timescale 1ns/1ps
module tb_pin_change_irq;
  localparam int W = 8;
  localparam int N = 2;
  localparam int T = N * W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [T-1:0] pin_lvl = '0;
  logic [T-1:0] pin_is_in = '1;
  logic [T-1:0] cap_val = '0;
  logic [N-1:0] port_rd = '0;
  logic         irq_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pin_change_irq #(.PORT_W(W), .NUM_PORTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_is_in(pin_is_in),
    .cap_val(cap_val), .port_rd(port_rd), .irq_n(irq_n));

  function automatic logic model_irq_n(input logic [T-1:0] l, input logic [T-1:0] d,
                                       input logic [T-1:0] s, input logic [N-1:0] r);
    logic any = 1'b0;
    for (int p = 0; p < N; p++) begin
      logic [W-1:0] m = (l[p*W +: W] ^ s[p*W +: W]) & d[p*W +: W];
      if (!r[p] && m != 0) any = 1'b1;
    end
    return !any;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    pin_lvl = 16'hA5C3;
    cap_val = 16'h0000;
    pin_is_in = '1;
    repeat (3) @(negedge clk);
    check("R1 in reset with mismatch", irq_n, 1'b1);
    cap_val = pin_lvl;
    rst_n = 1'b1;
    step();
    check("R1 after reset", irq_n, 1'b1);

    pin_lvl[3] = ~pin_lvl[3];
    step();
    check("R2 port0 bit3 flip", irq_n, 1'b0);
    pin_lvl[3] = cap_val[3];
    step();
    check("R4 revert", irq_n, 1'b1);

    pin_is_in[3] = 1'b0;
    pin_lvl[3] = ~cap_val[3];
    step();
    check("R3 output pin masked", irq_n, 1'b1);
    pin_lvl[3] = cap_val[3];
    step();
    check("R3 output pin toggled back", irq_n, 1'b1);
    pin_lvl[3] = ~cap_val[3];
    step();
    pin_is_in[3] = 1'b1;
    step();
    check("R7 output to input mismatch", irq_n, 1'b0);

    port_rd = 2'b01;
    step();
    check("R5 read port0 clears", irq_n, 1'b1);
    port_rd = 2'b00;
    cap_val[7:0] = pin_lvl[7:0];
    step();
    check("R5 after capture", irq_n, 1'b1);

    pin_lvl[12] = ~pin_lvl[12];
    pin_lvl[0]  = ~pin_lvl[0];
    step();
    check("R2 both ports", irq_n, 1'b0);
    port_rd = 2'b01;
    step();
    check("R6 read port0 keeps port1", irq_n, 1'b0);
    port_rd = 2'b00;
    cap_val[7:0] = pin_lvl[7:0];
    step();
    check("R6 port1 still pending", irq_n, 1'b0);
    port_rd = 2'b10;
    step();
    check("R5 read port1 clears", irq_n, 1'b1);
    port_rd = 2'b00;
    cap_val[15:8] = pin_lvl[15:8];
    step();
    check("R4 all clean", irq_n, 1'b1);

    pin_lvl[2] = ~pin_lvl[2];
    port_rd = 2'b10;
    step();
    check("R6 read port1 keeps port0", irq_n, 1'b0);
    port_rd = 2'b00;
    pin_lvl[2] = cap_val[2];
    step();
    check("R4 port0 revert", irq_n, 1'b1);

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 400; i++) begin
      logic [T-1:0] dmask;
      logic exp;
      pin_lvl   = T'($urandom);
      dmask     = T'($urandom) & T'($urandom) & T'($urandom);
      cap_val   = pin_lvl ^ dmask;
      pin_is_in = T'($urandom) | T'($urandom);
      port_rd   = (($urandom % 4) == 0) ? N'($urandom) : '0;
      exp = model_irq_n(pin_lvl, pin_is_in, cap_val, port_rd);
      step();
      check("R8 random", irq_n, exp);
    end
    finish_run();
  end
endmodule